// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers up to eight interrupt request lines and presents them to a processor as a single interrupt output. When the processor acknowledges, the block returns a byte-wide vector. It keeps three per-line registers: pending requests, lines in service and a blocking mask. The processor programs it through two byte registers. Address 0 is the command register and address 1 is the data register.

Software first writes a restart byte to the command register. It then writes, in order, to the data register: the vector base, the cascade byte and, if the restart byte asked for it, a mode byte. After that, data writes load the mask. Command writes carry end-of-service commands, priority rotation and the choice of which register the command address reads back. Inputs are either all edge-sensitive or all level-sensitive. The mode byte can make acknowledge retire the in-service bit at once.

A request that has vanished by acknowledge time still produces a vector, for the lowest line (7), and sets no in-service bit. A part strapped as a cascaded secondary answers an acknowledge only when the cascade address pins match its programmed line index.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, the mask is all ones (every line blocked) and `int_out` and `vec_valid` are low. Initialization is complete with vector base 0, lowest-priority line 7 and command reads showing the request register.
- R2: A command write with bit4=1 restarts initialization. Bit3=1 selects level inputs and bit0=1 means a mode byte follows. The next data writes load the vector base, then the cascade byte, then the mode byte only if bit0 was set. The restart clears the in-service register, makes line 7 lowest, selects request-register reads and turns auto-retire off. It leaves the mask unchanged.
- R3: Once initialization is complete, a data write loads the mask. A set bit stops that line from raising `int_out`. A data read returns the mask.
- R4: In edge mode, a rising input sets its request bit one clock later. The bit stays set after the input falls and clears when that line is granted. In level mode, the request bit copies the input one clock later.
- R5: `int_out` is high exactly when some unmasked request outranks every in-service bit. Masked requests still show in the request register.
- R6: On an accepted `ack` with a qualifying request, `vec_out` carries the vector base plus the winning line number and `vec_valid` pulses for one clock, both one clock after `ack`. The winner's in-service bit is set.
- R7: On an accepted `ack` with no qualifying request, `vec_out` carries the vector base plus 7 and the in-service register is left unchanged.
- R8: Command reads return the request register by default. A command write with bits4:3=01 and bit1=1 selects the in-service register when bit0=1 and the request register when bit0=0.
- R9: A command write with bits4:3=00 and bits7:5=001 (0x20) clears the highest-priority in-service bit. Bits7:5=011 clears the in-service bit numbered by bits2:0.
- R10: Bits7:5=110 makes line bits2:0 the lowest priority, so service order runs from the next line upward with wraparound. Bits7:5=101 clears the highest-priority in-service bit and makes that line the lowest.
- R11: When mode-byte bit1 is set, acknowledge sets no in-service bit.
- R12: With `is_slave` high, `ack` is honoured only when `casc_id` equals cascade-byte bits2:0. Otherwise it gives no `vec_valid` and changes no state. With `is_slave` low, `casc_id` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects the command register, 1 the data register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| irq | input | 8 | Interrupt request lines |
| is_slave | input | 1 | Strap: part is a cascaded secondary |
| casc_id | input | 3 | Cascade address from the primary |
| ack | input | 1 | Interrupt acknowledge strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned after acknowledge |
| vec_valid | output | 1 | One-clock marker for `vec_out` |

## Verification
Single-line requests separate vector arithmetic from priority. Paired requests on lines on either side of the rotation point show whether the lowest-line setting really reorders service. Nested requests, where a higher line arrives while a lower one is in service and a lower line arrives behind it, tell true preemption apart from simple first-come order. A level input dropped before acknowledge separates a genuine grant from the spurious line-7 answer. Random edge pulses mixed with acknowledges, end-of-service commands and priority changes are compared against a bench model of the request and in-service registers.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    INIT_DONE = 2'd0,
    INIT_BASE = 2'd1,
    INIT_CASC = 2'd2,
    INIT_MODE = 2'd3
  } init_st_t;

  localparam logic [2:0] OP_EOI_ANY = 3'b001;
  localparam logic [2:0] OP_EOI_ONE = 3'b011;
  localparam logic [2:0] OP_EOI_ROT = 3'b101;
  localparam logic [2:0] OP_SET_LOW = 3'b110;
endpackage

// File: rtl/pic_pick.sv
// Finds the highest-priority set bit under a rotating priority order.
// N must be a power of two so the index wraps naturally.
module pic_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  input  logic [IW-1:0] lowest,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] rank
);
  always_comb begin
    logic [IW-1:0] p;
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    p     = '0;
    for (int r = N - 1; r >= 0; r--) begin
      p = lowest + IW'(1) + IW'(r);
      if (bits[p]) begin
        found = 1'b1;
        idx   = p;
        rank  = IW'(r);
      end
    end
  end
endmodule

// File: rtl/pic_irr.sv
// Request capture: edge latch or level follower.
module pic_irr #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         level_mode,
  input  logic         restart,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] irq,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q, irr_q, irr_d;

  always_comb begin
    if (level_mode) irr_d = irq;
    else            irr_d = (irr_q | (irq & ~prev_q)) & ~clr;
    if (restart)    irr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq;
      irr_q  <= irr_d;
    end
  end

  assign irr = irr_q;
endmodule

// File: rtl/pic_regs.sv
// Init sequencer, mask, in-service register and priority state.
module pic_regs
  import pic_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [7:0]    wr_data,
  input  logic          grant,
  input  logic [IW-1:0] win_idx,
  input  logic          top_found,
  input  logic [IW-1:0] top_idx,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  isr,
  output logic [7:0]    base,
  output logic [IW-1:0] casc_sel,
  output logic          level_mode,
  output logic          auto_eoi,
  output logic [IW-1:0] lowest,
  output logic          read_isr,
  output logic          ready,
  output logic          restart
);
  init_st_t      st_q, st_d;
  logic [N-1:0]  mask_q, mask_d, isr_q, isr_d;
  logic [7:0]    base_q, base_d;
  logic [IW-1:0] casc_q, casc_d, low_q, low_d;
  logic          ltim_q, ltim_d, ic4_q, ic4_d, aeoi_q, aeoi_d, ris_q, ris_d;
  logic          cmd_init, cmd_op2, cmd_op3, dat_wr, upd;

  assign ready    = (st_q == INIT_DONE);
  assign cmd_init = wr_en && !addr && wr_data[4];
  assign cmd_op2  = wr_en && !addr && !wr_data[4] && !wr_data[3] && ready;
  assign cmd_op3  = wr_en && !addr && !wr_data[4] && wr_data[3];
  assign dat_wr   = wr_en && addr;
  assign upd      = wr_en | grant;
  assign restart  = cmd_init;

  always_comb begin
    st_d = st_q;   mask_d = mask_q; isr_d = isr_q; base_d = base_q;
    casc_d = casc_q; low_d = low_q; ltim_d = ltim_q; ic4_d = ic4_q;
    aeoi_d = aeoi_q; ris_d = ris_q;
    if (grant && !aeoi_q) isr_d[win_idx] = 1'b1;
    if (cmd_op2) begin
      unique case (wr_data[7:5])
        OP_EOI_ANY: if (top_found) isr_d[top_idx] = 1'b0;
        OP_EOI_ONE: isr_d[wr_data[IW-1:0]] = 1'b0;
        OP_EOI_ROT: if (top_found) begin
          isr_d[top_idx] = 1'b0;
          low_d          = top_idx;
        end
        OP_SET_LOW: low_d = wr_data[IW-1:0];
        default: ;
      endcase
    end
    if (cmd_op3 && wr_data[1]) ris_d = wr_data[0];
    if (dat_wr) begin
      unique case (st_q)
        INIT_DONE: mask_d = wr_data[N-1:0];
        INIT_BASE: begin base_d = wr_data; st_d = INIT_CASC; end
        INIT_CASC: begin
          casc_d = wr_data[IW-1:0];
          st_d   = ic4_q ? INIT_MODE : INIT_DONE;
        end
        INIT_MODE: begin aeoi_d = wr_data[1]; st_d = INIT_DONE; end
        default: ;
      endcase
    end
    if (cmd_init) begin
      st_d   = INIT_BASE;
      ltim_d = wr_data[3];
      ic4_d  = wr_data[0];
      isr_d  = '0;
      low_d  = IW'(N - 1);
      ris_d  = 1'b0;
      aeoi_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= INIT_DONE; mask_q <= '1; isr_q <= '0; base_q <= '0;
      casc_q <= '0; low_q <= IW'(N - 1); ltim_q <= 1'b0; ic4_q <= 1'b0;
      aeoi_q <= 1'b0; ris_q <= 1'b0;
    end else if (upd) begin
      st_q <= st_d; mask_q <= mask_d; isr_q <= isr_d; base_q <= base_d;
      casc_q <= casc_d; low_q <= low_d; ltim_q <= ltim_d; ic4_q <= ic4_d;
      aeoi_q <= aeoi_d; ris_q <= ris_d;
    end
  end

  assign mask       = mask_q;
  assign isr        = isr_q;
  assign base       = base_q;
  assign casc_sel   = casc_q;
  assign level_mode = ltim_q;
  assign auto_eoi   = aeoi_q;
  assign lowest     = low_q;
  assign read_isr   = ris_q;
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter  int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic [N-1:0]  irq,
  input  logic          is_slave,
  input  logic [IW-1:0] casc_id,
  input  logic          ack,
  output logic          int_out,
  output logic [7:0]    vec_out,
  output logic          vec_valid
);
  logic [N-1:0]  irr_w, isr_w, mask_w, req_w, clr_w;
  logic [7:0]    base_w, vec_d;
  logic [IW-1:0] casc_w, low_w, win_idx, win_rank, top_idx, top_rank;
  logic          ltim_w, aeoi_w, ris_w, ready_w, restart_w;
  logic          win_found, top_found, ack_ok, grant;
  logic [7:0]    vec_q;
  logic          vvld_q;

  assign req_w   = irr_w & ~mask_w;
  assign int_out = ready_w && win_found && (!top_found || (win_rank < top_rank));
  assign ack_ok  = ack && ready_w && (!is_slave || (casc_id == casc_w));
  assign grant   = ack_ok && int_out;
  assign clr_w   = grant ? (N'(1) << win_idx) : '0;
  assign vec_d   = base_w + 8'(grant ? win_idx : IW'(N - 1));
  assign rd_data = addr ? 8'(mask_w) : (ris_w ? 8'(isr_w) : 8'(irr_w));

  pic_irr #(.N(N)) u_irr (
    .clk(clk), .rst_n(rst_n), .level_mode(ltim_w), .restart(restart_w),
    .clr(clr_w), .irq(irq), .irr(irr_w)
  );

  pic_pick #(.N(N), .IW(IW)) u_pick_req (
    .bits(req_w), .lowest(low_w), .found(win_found), .idx(win_idx), .rank(win_rank)
  );

  pic_pick #(.N(N), .IW(IW)) u_pick_isr (
    .bits(isr_w), .lowest(low_w), .found(top_found), .idx(top_idx), .rank(top_rank)
  );

  pic_regs #(.N(N), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .grant(grant), .win_idx(win_idx), .top_found(top_found), .top_idx(top_idx),
    .mask(mask_w), .isr(isr_w), .base(base_w), .casc_sel(casc_w),
    .level_mode(ltim_w), .auto_eoi(aeoi_w), .lowest(low_w), .read_isr(ris_w),
    .ready(ready_w), .restart(restart_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vvld_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      vvld_q <= ack_ok;
      if (ack_ok) vec_q <= vec_d;
    end
  end

  assign vec_out   = vec_q;
  assign vec_valid = vvld_q;
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ack,
  input logic         int_out,
  input logic         vec_valid,
  input logic [7:0]   vec_out,
  input logic [N-1:0] isr,
  input logic [N-1:0] mask,
  input logic [7:0]   base,
  input logic         auto_eoi,
  input logic         ready,
  input logic         wr_en,
  input logic         addr,
  input logic [7:0]   wr_data
);
  p_vec_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack));

  p_isr_one_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr & ~$past(isr)) <= 1);

  p_aeoi_no_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(auto_eoi) |-> ((isr & ~$past(isr)) == '0));

  p_spur_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !$past(int_out)) |-> (vec_out == base + 8'(N - 1)));

  p_spur_no_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !$past(int_out)) |-> ((isr & ~$past(isr)) == '0));

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr && ready) |-> (mask == $past(wr_data[N-1:0])));
endmodule

bind pic_ctrl pic_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .int_out(int_out),
  .vec_valid(vec_valid), .vec_out(vec_out), .isr(isr_w), .mask(mask_w),
  .base(base_w), .auto_eoi(aeoi_w), .ready(ready_w), .wr_en(wr_en),
  .addr(addr), .wr_data(wr_data)
);

// File: tb/pic_ctrl_test.sv
module pic_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n, wr_en, addr, is_slave, ack;
  logic [7:0] wr_data, irq;
  logic [2:0] casc_id;
  logic [7:0] rd_data, vec_out;
  logic       int_out, vec_valid;
  int n_chk = 0, n_bad = 0;
  logic [7:0] d;

  always #4 clk = ~clk;

  pic_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .is_slave(is_slave), .casc_id(casc_id),
    .ack(ack), .int_out(int_out), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  task automatic tick; @(posedge clk); #2; endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] v);
    addr = a; wr_data = v; wr_en = 1'b1; tick(); wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    addr = a; #1 v = rd_data;
  endtask

  task automatic do_ack; ack = 1'b1; tick(); ack = 1'b0; endtask

  task automatic pulse(logic [7:0] r); irq = r; tick(); irq = '0; tick(); endtask

  task automatic setup(logic [7:0] i1, logic [7:0] b, logic [7:0] c, logic [7:0] m);
    wr(1'b0, i1); wr(1'b1, b); wr(1'b1, c);
    if (i1[0]) wr(1'b1, m);
  endtask

  function automatic int top(logic [7:0] v, int lp);
    for (int r = 0; r < 8; r++) begin
      int p = (lp + 1 + r) % 8;
      if (v[p]) return p;
    end
    return -1;
  endfunction

  function automatic int rnk(int p, int lp);
    return (p - lp - 1 + 16) % 8;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] m_irr, m_isr, r, exp_vec;
    int lp, c, rq, it;
    bit exp_int;
    rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wr_data = '0; irq = '0;
    is_slave = 1'b0; casc_id = '0; ack = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1; tick();

    // R1 reset state
    chk("R1 int_out", int_out, 0);
    chk("R1 vec_valid", vec_valid, 0);
    rd(1'b1, d); chk("R1 mask all ones", d, 8'hFF);
    rd(1'b0, d); chk("R1 irr read", d, 8'h00);
    do_ack();
    chk("R1 ack accepted", vec_valid, 1);
    chk("R7 spurious vector base 0", vec_out, 8'h07);

    // Edge mode, base 0x40
    setup(8'h11, 8'h40, 8'h04, 8'h00);
    wr(1'b1, 8'h00);
    rd(1'b1, d); chk("R3 mask readback", d, 8'h00);
    pulse(8'h08);
    chk("R5 int_out on line3", int_out, 1);
    rd(1'b0, d); chk("R4 edge latched after input fell", d, 8'h08);
    do_ack();
    chk("R6 vec_valid", vec_valid, 1);
    chk("R6 vector line3", vec_out, 8'h43);
    tick();
    chk("R6 vec_valid one cycle", vec_valid, 0);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R8 isr read", d, 8'h08);
    chk("R5 int_out low when served", int_out, 0);
    wr(1'b0, 8'h0A);
    rd(1'b0, d); chk("R4 grant clears request", d, 8'h00);

    // Nesting
    pulse(8'h20);
    chk("R5 lower line blocked by isr", int_out, 0);
    pulse(8'h02);
    chk("R5 higher line preempts", int_out, 1);
    do_ack();
    chk("R6 vector line1", vec_out, 8'h41);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R6 nested isr", d, 8'h0A);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R9 nonspecific eoi", d, 8'h08);
    chk("R5 line5 still blocked", int_out, 0);
    wr(1'b0, 8'h63);
    rd(1'b0, d); chk("R9 specific eoi line3", d, 8'h00);
    chk("R5 line5 now raises", int_out, 1);
    do_ack();
    chk("R6 vector line5", vec_out, 8'h45);
    wr(1'b0, 8'h20);

    // Mask
    wr(1'b1, 8'h10);
    pulse(8'h10);
    chk("R3 masked line no int", int_out, 0);
    wr(1'b0, 8'h0A);
    rd(1'b0, d); chk("R5 masked request visible", d, 8'h10);
    wr(1'b1, 8'h00);
    chk("R3 unmask raises", int_out, 1);
    do_ack();
    chk("R6 vector line4", vec_out, 8'h44);
    wr(1'b0, 8'h20);

    // Priority rotation
    wr(1'b0, 8'hC2);
    pulse(8'h12);
    do_ack();
    chk("R10 lowest=2 serves line4 before line1", vec_out, 8'h44);
    wr(1'b0, 8'h20);
    do_ack();
    chk("R10 then line1", vec_out, 8'h41);
    wr(1'b0, 8'hA0);
    pulse(8'h81);
    do_ack();
    chk("R10 rotate makes line1 lowest: line7 before line0", vec_out, 8'h47);
    wr(1'b0, 8'h20);
    do_ack();
    chk("R10 then line0", vec_out, 8'h40);
    wr(1'b0, 8'h20);

    // Restart clears isr; level mode and spurious
    pulse(8'h04);
    do_ack();
    chk("R6 vector line2", vec_out, 8'h42);
    setup(8'h19, 8'h80, 8'h04, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R2 restart clears isr", d, 8'h00);
    rd(1'b1, d); chk("R2 mask kept", d, 8'h00);
    wr(1'b0, 8'h0A);
    irq = 8'h10; tick();
    chk("R4 level request raises", int_out, 1);
    rd(1'b0, d); chk("R4 level irr", d, 8'h10);
    irq = 8'h00; tick();
    chk("R4 level follows input low", int_out, 0);
    do_ack();
    chk("R7 lost request vector", vec_out, 8'h87);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R7 isr untouched", d, 8'h00);

    // Auto retire
    setup(8'h11, 8'h20, 8'h04, 8'h02);
    pulse(8'h40);
    do_ack();
    chk("R11 vector line6", vec_out, 8'h26);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R11 no isr bit", d, 8'h00);

    // Secondary part
    is_slave = 1'b1; casc_id = 3'd3;
    setup(8'h11, 8'h70, 8'h02, 8'h00);
    wr(1'b1, 8'h00);
    pulse(8'h01);
    do_ack();
    chk("R12 wrong id no vector", vec_valid, 0);
    chk("R12 request still pending", int_out, 1);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); chk("R12 isr untouched", d, 8'h00);
    casc_id = 3'd2;
    do_ack();
    chk("R12 matching id vector", vec_out, 8'h70);
    chk("R12 matching id valid", vec_valid, 1);
    rd(1'b0, d); chk("R12 isr set", d, 8'h01);
    is_slave = 1'b0; casc_id = 3'd5;

    // No mode byte
    setup(8'h10, 8'h30, 8'h04, 8'h00);
    wr(1'b1, 8'h5A);
    rd(1'b1, d); chk("R2 three-byte init then mask", d, 8'h5A);

    // Random phase
    void'($urandom(32'd5150));
    setup(8'h11, 8'h08, 8'h04, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h0B);
    m_irr = '0; m_isr = '0; lp = 7;
    for (int k = 0; k < 400; k++) begin
      r = 8'($urandom_range(0, 255)) & 8'($urandom_range(0, 255));
      pulse(r);
      m_irr = m_irr | r;
      rq = top(m_irr, lp);
      it = top(m_isr, lp);
      exp_int = (rq >= 0) && ((it < 0) || (rnk(rq, lp) < rnk(it, lp)));
      chk("R5 random int_out", int_out, exp_int);
      c = $urandom_range(0, 3);
      if (c <= 1) begin
        do_ack();
        if (exp_int) begin
          exp_vec = 8'h08 + 8'(rq);
          m_isr[rq] = 1'b1;
          m_irr[rq] = 1'b0;
        end else exp_vec = 8'h0F;
        chk("R6 random vector", vec_out, exp_vec);
      end else if (c == 2) begin
        wr(1'b0, 8'h20);
        if (it >= 0) m_isr[it] = 1'b0;
      end else begin
        int lv = $urandom_range(0, 7);
        wr(1'b0, 8'hC0 | 8'(lv));
        lp = lv;
      end
      rd(1'b0, d); chk("R9 random isr", d, m_isr);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule